// File: doc/BRIEF.md
# Frame-Committing Output Buffer with Fill Interrupt

This block sits between an on-chip producer of framed 16-bit words and an external processor or DMA engine that drains them through a slave port. The producer presents one word per cycle with a valid flag, plus markers for the first and last word of each frame. Words are stored in a circular memory. The reader does not see a frame until its last word has been stored, so the reader only ever takes complete frames.

If a frame does not fit in the free space, the whole frame is discarded, including the words already stored. The write pointer returns to the frame's start, a sticky overflow flag is set, and words are ignored until the next start marker. The reader side has a chip select, a read strobe, an output enable that controls the tri-state data bus, an empty flag and an interrupt request. The interrupt is asserted while the committed fill is at or above a threshold that the host programs. A small register port holds the threshold, the overflow flag and the committed fill.

Top module: `frfifo_top`

## Requirements
- R1: After reset, hostEmpty is 1, hostIrq is 0, the committed fill (register address 2) is 0 and the overflow flag (address 1, bit 0) is 0.
- R2: Words of a frame whose end marker has not yet been stored are not visible. hostEmpty and the fill stay unchanged until the end word is written.
- R3: A read strobe (hostRd and hostCs high for one clock) while the buffer holds data loads the oldest committed word into the output register after that edge. Words come out in write order across pointer wrap.
- R4: A read strobe while the buffer is empty leaves the output word and the read position unchanged. A later frame is read correctly.
- R5: hostData is driven only while hostCs and hostOe are both 1. Otherwise it is high impedance.
- R6: hostIrq is 1 exactly while the committed fill is greater than or equal to the threshold. It drops when reads bring the fill below it.
- R7: The threshold register is at address 0 (the low log2(DEPTH)+1 bits are used). It resets to THRESH_INIT and can be written and read back.
- R8: A word that arrives when stored words equal DEPTH discards the whole current frame, including its stored words. Committed data and fill are unchanged, and the overflow flag is set.
- R9: After an overflow, words are ignored until a word with the start marker arrives. That frame is then accepted normally.
- R10: The overflow flag is sticky. Writing 1 to bit 0 of address 1 clears it, and writing 0 leaves it set.
- R11: A word that has no start marker and arrives outside a frame is ignored. A start marker inside an open frame discards the partial frame and begins a new one.
- R12: A frame exactly as long as the free space is accepted. With an empty buffer a frame of DEPTH words fits, and one of DEPTH+1 words is discarded entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrValid | input | 1 | Producer word valid |
| wrSof | input | 1 | Word is the first of a frame |
| wrEof | input | 1 | Word is the last of a frame |
| wrData | input | DW | Producer word |
| hostCs | input | 1 | Reader chip select |
| hostOe | input | 1 | Reader output enable for the tri-state bus |
| hostRd | input | 1 | Reader read strobe |
| hostData | inout | DW | Reader data bus, tri-state |
| hostEmpty | output | 1 | No committed word available |
| hostIrq | output | 1 | Committed fill at or above the threshold |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data (combinational) |

## Verification
The bench uses a 16-word configuration. It writes single frames of every length from 1 to the full depth, then reads each back. This separates correct commit and ordering from faults at one length, and the running total forces many pointer wraps. A threshold sweep over eight values fills and drains the buffer one word at a time, which shows an off-by-one in the interrupt compare in both directions. Overflow is tried in three ways: against committed data, with an oversized frame into an empty buffer, and with an aborted frame restarted by a new start marker. Each is followed by readback, which shows whether stored words were rolled back or left behind.

// File: rtl/frfifo_pkg.sv
package frfifo_pkg;
  typedef struct packed {
    logic wrEn;        // store wrData at the base position
    logic fromCommit;  // base is the committed pointer (frame start)
    logic commit;      // the stored word closes the frame
    logic rollback;    // drop the open frame
    logic rdEn;        // pop one committed word
  } fifoStrobe_t;
endpackage

// File: rtl/frfifo_data.sv
module frfifo_data
  import frfifo_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 256
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  fifoStrobe_t                strobe,
  input  logic [DW-1:0]              wrData,
  output logic [$clog2(DEPTH):0]     fill,
  output logic [$clog2(DEPTH):0]     pendUsed,
  output logic [DW-1:0]              outWord
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wrPtr, commitPtr, rdPtr;
  logic [PW-1:0] basePtr, nextPtr;

  assign basePtr  = strobe.fromCommit ? commitPtr : wrPtr;
  assign nextPtr  = basePtr + PW'(1);
  assign fill     = commitPtr - rdPtr;
  assign pendUsed = wrPtr - rdPtr;

  always_ff @(posedge clk) begin
    if (strobe.wrEn && !strobe.rollback)
      mem[basePtr[AW-1:0]] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      commitPtr <= '0;
    end else if (strobe.rollback) begin
      wrPtr <= commitPtr;
    end else if (strobe.wrEn) begin
      wrPtr <= nextPtr;
      if (strobe.commit) commitPtr <= nextPtr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr   <= '0;
      outWord <= '0;
    end else if (strobe.rdEn) begin
      outWord <= mem[rdPtr[AW-1:0]];
      rdPtr   <= rdPtr + PW'(1);
    end
  end

  // R12
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pendUsed <= PW'(DEPTH)) && (fill <= pendUsed));

  // R8
  rollback_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rollback |=> pendUsed == fill);

  // R4
  rd_nonempty_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdEn |-> fill != '0);
endmodule

// File: rtl/frfifo_ctrl.sv
module frfifo_ctrl
  import frfifo_pkg::*;
#(
  parameter int DEPTH       = 256,
  parameter int THRESH_INIT = 128
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrValid,
  input  logic                       wrSof,
  input  logic                       wrEof,
  input  logic                       hostCs,
  input  logic                       hostRd,
  input  logic                       regWr,
  input  logic [1:0]                 regAddr,
  input  logic [15:0]                regWdata,
  input  logic [$clog2(DEPTH):0]     fill,
  input  logic [$clog2(DEPTH):0]     pendUsed,
  output fifoStrobe_t                strobe,
  output logic                       hostEmpty,
  output logic                       hostIrq,
  output logic [15:0]                regRdata
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam logic [1:0] ADDR_THR  = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_FILL = 2'd2;

  logic          inFrame, ovfFlag;
  logic [PW-1:0] thresh;
  logic [PW-1:0] baseUsed;
  logic          accept, noRoom, ovfClear;

  assign accept   = wrValid && (wrSof || inFrame);
  assign baseUsed = wrSof ? fill : pendUsed;
  assign noRoom   = baseUsed == PW'(DEPTH);
  assign ovfClear = regWr && (regAddr == ADDR_STAT) && regWdata[0];

  always_comb begin
    strobe            = '0;
    strobe.rdEn       = hostCs && hostRd && (fill != '0);
    if (accept) begin
      if (noRoom) begin
        strobe.rollback = 1'b1;
      end else begin
        strobe.wrEn       = 1'b1;
        strobe.fromCommit = wrSof;
        strobe.commit     = wrEof;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inFrame <= 1'b0;
      ovfFlag <= 1'b0;
      thresh  <= PW'(THRESH_INIT);
    end else begin
      if (accept) inFrame <= !noRoom && !wrEof;
      if (accept && noRoom) ovfFlag <= 1'b1;
      else if (ovfClear)    ovfFlag <= 1'b0;
      if (regWr && regAddr == ADDR_THR) thresh <= regWdata[PW-1:0];
    end
  end

  assign hostEmpty = fill == '0;
  assign hostIrq   = fill >= thresh;

  always_comb begin
    case (regAddr)
      ADDR_THR:  regRdata = 16'(thresh);
      ADDR_STAT: regRdata = {15'd0, ovfFlag};
      ADDR_FILL: regRdata = 16'(fill);
      default:   regRdata = '0;
    endcase
  end

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ovfFlag) && !$past(ovfClear)) |-> ovfFlag);

  // R9
  drop_after_ovf_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rollback |=> !inFrame);

  // R6
  empty_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostEmpty && thresh != '0) |-> !hostIrq);
endmodule

// File: rtl/frfifo_top.sv
module frfifo_top
  import frfifo_pkg::*;
#(
  parameter int DW          = 16,
  parameter int DEPTH       = 256,
  parameter int THRESH_INIT = 128
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrValid,
  input  logic          wrSof,
  input  logic          wrEof,
  input  logic [DW-1:0] wrData,
  input  logic          hostCs,
  input  logic          hostOe,
  input  logic          hostRd,
  inout  wire  [DW-1:0] hostData,
  output logic          hostEmpty,
  output logic          hostIrq,
  input  logic          regWr,
  input  logic [1:0]    regAddr,
  input  logic [15:0]   regWdata,
  output logic [15:0]   regRdata
);
  localparam int PW = $clog2(DEPTH) + 1;

  fifoStrobe_t   strobe;
  logic [PW-1:0] fill, pendUsed;
  logic [DW-1:0] outWord;

  frfifo_ctrl #(.DEPTH(DEPTH), .THRESH_INIT(THRESH_INIT)) ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrSof(wrSof), .wrEof(wrEof),
    .hostCs(hostCs), .hostRd(hostRd), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .fill(fill), .pendUsed(pendUsed), .strobe(strobe),
    .hostEmpty(hostEmpty), .hostIrq(hostIrq), .regRdata(regRdata)
  );

  frfifo_data #(.DW(DW), .DEPTH(DEPTH)) data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .fill(fill), .pendUsed(pendUsed), .outWord(outWord)
  );

  assign hostData = (hostCs && hostOe) ? outWord : {DW{1'bz}};
endmodule

// File: tb/frfifo_top_test.sv
module frfifo_top_test;
  localparam int DW = 16;
  localparam int DEPTH = 16;
  localparam int THR0 = 4;

  logic clk = 0, rstN = 0;
  logic wrValid = 0, wrSof = 0, wrEof = 0;
  logic [DW-1:0] wrData = '0;
  logic hostCs = 0, hostOe = 0, hostRd = 0;
  wire  [DW-1:0] hostData;
  logic hostEmpty, hostIrq;
  logic regWr = 0;
  logic [1:0] regAddr = 0;
  logic [15:0] regWdata = 0, regRdata;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  frfifo_top #(.DW(DW), .DEPTH(DEPTH), .THRESH_INIT(THR0)) uut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrSof(wrSof), .wrEof(wrEof),
    .wrData(wrData), .hostCs(hostCs), .hostOe(hostOe), .hostRd(hostRd),
    .hostData(hostData), .hostEmpty(hostEmpty), .hostIrq(hostIrq),
    .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata)
  );

  function automatic logic [15:0] pat(int s, int i);
    return 16'(s * 97 + i * 13 + 'h1234);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pushWord(logic [15:0] d, logic s, logic e);
    @(negedge clk);
    wrValid = 1; wrSof = s; wrEof = e; wrData = d;
    @(negedge clk);
    wrValid = 0; wrSof = 0; wrEof = 0;
  endtask

  task automatic sendFrame(int len, int seed);
    for (int i = 0; i < len; i++) pushWord(pat(seed, i), i == 0, i == len - 1);
  endtask

  task automatic readWord(output logic [15:0] v);
    @(negedge clk);
    hostCs = 1; hostOe = 1; hostRd = 1;
    @(negedge clk);
    hostRd = 0;
    #1 v = hostData;
  endtask

  task automatic regWrite(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWr = 1;
    @(negedge clk);
    regWr = 0;
  endtask

  task automatic regRead(logic [1:0] a, output logic [15:0] v);
    regAddr = a;
    #1 v = regRdata;
  endtask

  task automatic readFrame(int len, int seed, string req);
    logic [15:0] v;
    for (int i = 0; i < len; i++) begin
      readWord(v);
      chk(req, v, pat(seed, i));
    end
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 / R7 reset state
    chk("R1 empty", hostEmpty, 1);
    chk("R1 irq", hostIrq, 0);
    regRead(2, v); chk("R1 fill", v, 0);
    regRead(1, v); chk("R1 ovf", v, 0);
    regRead(0, v); chk("R7 thr default", v, THR0);
    // R5 tri-state
    hostCs = 0; hostOe = 0; #1 chk("R5 z idle", hostData === 16'hzzzz, 1);
    hostCs = 1; hostOe = 0; #1 chk("R5 z no oe", hostData === 16'hzzzz, 1);
    hostCs = 0; hostOe = 1; #1 chk("R5 z no cs", hostData === 16'hzzzz, 1);
    hostCs = 1; hostOe = 1; #1 chk("R5 driven", hostData === 16'h0000, 1);
    hostCs = 0; hostOe = 0;

    // R3 / R12 / R6 sweep over every frame length, wrapping pointers
    for (int len = 1; len <= DEPTH; len++) begin
      sendFrame(len, len);
      regRead(2, v); chk("R12 fill", v, len);
      chk("R6 irq", hostIrq, len >= THR0);
      readFrame(len, len, "R3 order");
      chk("R3 empty after", hostEmpty, 1);
      chk("R6 irq after", hostIrq, 0);
    end

    // R2 partial frame invisible
    pushWord(pat(50, 0), 1, 0);
    pushWord(pat(50, 1), 0, 0);
    chk("R2 empty open", hostEmpty, 1);
    regRead(2, v); chk("R2 fill open", v, 0);
    pushWord(pat(50, 2), 0, 1);
    regRead(2, v); chk("R2 fill closed", v, 3);
    readFrame(3, 50, "R2 data");

    // R4 read on empty keeps last word
    readWord(v); chk("R4 hold", v, pat(50, 2));
    sendFrame(2, 51);
    readFrame(2, 51, "R4 next frame");

    // R6 / R7 threshold sweep
    for (int t = 1; t <= 8; t++) begin
      regWrite(0, 16'(t));
      regRead(0, v); chk("R7 thr rb", v, t);
      for (int n = 1; n <= 8; n++) begin
        pushWord(pat(60 + t, n), 1, 1);
        chk("R6 rise", hostIrq, n >= t);
      end
      for (int n = 7; n >= 0; n--) begin
        readWord(v);
        chk("R6 fall", hostIrq, n >= t);
      end
    end
    regWrite(0, THR0);

    // R8 / R9 overflow against committed data
    sendFrame(10, 70);
    for (int i = 0; i < 10; i++) pushWord(pat(71, i), i == 0, i == 9);
    regRead(2, v); chk("R8 fill kept", v, 10);
    regRead(1, v); chk("R8 ovf set", v, 1);
    pushWord(pat(72, 0), 0, 1);
    regRead(2, v); chk("R9 ignored", v, 10);
    sendFrame(3, 73);
    regRead(2, v); chk("R9 accepted", v, 13);
    readFrame(10, 70, "R8 data kept");
    readFrame(3, 73, "R9 data");

    // R10 sticky / clear
    regWrite(1, 0);
    regRead(1, v); chk("R10 write0", v, 1);
    regWrite(1, 1);
    regRead(1, v); chk("R10 clear", v, 0);

    // R12 oversized frame into empty buffer
    sendFrame(DEPTH + 1, 80);
    regRead(2, v); chk("R12 oversize fill", v, 0);
    regRead(1, v); chk("R12 oversize ovf", v, 1);
    regWrite(1, 1);
    sendFrame(DEPTH, 81);
    regRead(2, v); chk("R12 full frame", v, DEPTH);
    regRead(1, v); chk("R12 no ovf", v, 0);
    readFrame(DEPTH, 81, "R12 data");

    // R11 stray words and restart
    pushWord(16'hdead, 0, 0);
    pushWord(16'hbeef, 0, 1);
    regRead(2, v); chk("R11 stray", v, 0);
    pushWord(pat(90, 0), 1, 0);
    pushWord(pat(90, 1), 0, 0);
    pushWord(pat(90, 2), 0, 0);
    sendFrame(2, 91);
    regRead(2, v); chk("R11 restart fill", v, 2);
    readFrame(2, 91, "R11 restart data");
    chk("R11 empty", hostEmpty, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule